// File: doc/BRIEF.md
# Queued Task Descriptor Chain Walker

The walker turns one queued storage task into a list of data-transfer segments. A per-slot descriptor table sits in a word-wide memory. Each slot holds a task descriptor, and the link descriptor follows it directly. The link points at a contiguous run of transfer descriptors, one per data segment.

The host pulses `start` with a slot tag. The walker then reads the descriptors one 32-bit word at a time and checks the attribute bits of each descriptor. It sends one segment record per transfer descriptor over a valid/ready handshake. It finishes with a `done` pulse that carries the task's block count, block address and direction. A malformed chain ends the walk with an `err` pulse instead, together with a fault code and the slot tag. The reserved direct-command slot has no data chain.

The descriptor sizes are chosen at run time and latched at `start`:
- task descriptor: 8 or 16 bytes;
- 32-bit addressing: 8-byte link and transfer descriptors;
- 64-bit addressing: 16-byte link descriptors, and 16-byte or 12-byte (short mode) transfer descriptors.

The controller states and their transitions:
- IDLE goes to TASK_A on `start`.
- TASK_A (attribute word of the task descriptor) goes to TASK_B (block address word).
- TASK_B goes to LINK_A (attribute word of the link descriptor).
- LINK_A goes to LINK_B (link address word), or to DONE for the direct-command slot.
- LINK_B goes to XFER_A (attribute and length word of a transfer descriptor).
- XFER_A goes to XFER_B (low address word).
- XFER_B goes to XFER_C (high address word, 64-bit only), or to EMIT.
- XFER_C goes to EMIT.
- EMIT goes to DONE on the end bit, back to XFER_A for the next descriptor, or to FAULT at the segment limit.
- A failed attribute check in TASK_A, LINK_A or XFER_A goes to FAULT.
- DONE and FAULT each last one cycle and return to IDLE.

Each fetch state takes two cycles: one to issue the read and one to take the data.

Top module: `qdw_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_rd_en`, `seg_valid`, `done` and `err` are all low.
- R2: Slot addressing follows these rules:
  - the task descriptor of tag t is read first, at `cfg_tbl_base + t*(T+L)`;
  - T is 16 when `cfg_task16` is set, else 8;
  - L is 16 when `cfg_addr64` is set, else 8;
  - the link descriptor is read at slot + T.
- R3: Attribute checks:
  - the attribute bits of every descriptor are: bit 0 valid, bit 1 end, bits 5:3 action;
  - the task must be valid with action 5, the link valid with action 6, and each transfer valid with action 4;
  - a failure pulses `err` with `err_code` 1 (task), 2 (link) or 3 (transfer), `err_tag` set to the tag, and no `done`.
- R4: Task decoding:
  - in task word 0, bit 12 is the direction and bits 31:16 are the block count;
  - word 1 (byte offset 4) is the block address;
  - all three are presented on `task_dir`, `task_blk_cnt` and `task_blk_addr` while `done` is high.
- R5: Link and transfer layout:
  - the link word at byte offset 4 holds the transfer table address;
  - transfer descriptor i sits at that address + i*X;
  - X is 8 with 32-bit addressing, 16 with 64-bit addressing, and 12 with 64-bit addressing in short mode.
- R6: Segment records:
  - each transfer descriptor gives one record, in table order;
  - `seg_len` is word 0 bits 31:16;
  - `seg_addr` is the word at offset 4, plus the word at offset 8 as the upper half with 64-bit addressing (upper half zero otherwise);
  - `seg_dir` is the task direction;
  - `seg_last` is the end bit.
- R7: While `seg_valid` is high and `seg_ready` is low, the record holds unchanged and the walk stalls.
- R8: If MAX_SEGS records are accepted and none had the end bit, the walk stops and pulses `err` with `err_code` 4.
- R9: Direct-command slot (tag DCMD_TAG, 31 by default):
  - its link descriptor must have valid clear and end set;
  - the walk then pulses `done` with no segment records;
  - any other link attribute gives `err_code` 5.
- R10: A `start` pulse while `busy` is high is ignored, and the running walk completes unchanged.
- R11: Memory reads:
  - each read fetches one word-aligned 32-bit word;
  - the data is taken one cycle after the read;
  - no read is issued in the cycle after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| start_tag | input | TAG_W | Slot tag to walk |
| cfg_tbl_base | input | ADDR_W | Byte address of the slot table |
| cfg_task16 | input | 1 | Task descriptors are 16 bytes |
| cfg_addr64 | input | 1 | 64-bit addressing layout |
| cfg_short_xfer | input | 1 | 12-byte transfer descriptors with 64-bit addressing |
| busy | output | 1 | Walk in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Byte address of the word read |
| mem_rd_data | input | 32 | Read data, one cycle after the strobe |
| seg_valid | output | 1 | Segment record valid |
| seg_ready | input | 1 | Segment record accepted |
| seg_addr | output | 64 | Segment data address |
| seg_len | output | 16 | Segment byte length |
| seg_dir | output | 1 | Transfer direction of the task |
| seg_last | output | 1 | End bit of the descriptor |
| done | output | 1 | Walk completed |
| task_dir | output | 1 | Task direction |
| task_blk_cnt | output | 16 | Task block count |
| task_blk_addr | output | 32 | Task block address |
| err | output | 1 | Walk aborted |
| err_code | output | 3 | Fault code (1 task, 2 link, 3 transfer, 4 limit, 5 direct-command link) |
| err_tag | output | TAG_W | Tag of the walk |

## Verification
A wrong address step shows up on the very next read, because the read address of every fetch state is visible on `mem_rd_addr`. It then corrupts the first record built from that read, so the error appears within a few cycles of `start`. A broken state transition, a wrong length register or a wrong segment counter shows up differently: records are missing, come out in the wrong order or carry wrong fields, or the final `done`/`err` pulse carries the wrong code. The bench compares every record and every final pulse against the chain it wrote, while `seg_ready` stalls at random, so a lost hold or a dropped record is caught on the handshake where it happens.

// File: rtl/qdw_pkg.sv
package qdw_pkg;

    // action codes in attribute bits 5:3
    localparam logic [2:0] ACT_XFER = 3'd4;
    localparam logic [2:0] ACT_TASK = 3'd5;
    localparam logic [2:0] ACT_LINK = 3'd6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TASK_A,
        ST_TASK_B,
        ST_LINK_A,
        ST_LINK_B,
        ST_XFER_A,
        ST_XFER_B,
        ST_XFER_C,
        ST_EMIT,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_TASK  = 3'd1,
        FLT_LINK  = 3'd2,
        FLT_XFER  = 3'd3,
        FLT_LIMIT = 3'd4,
        FLT_DCMD  = 3'd5
    } fault_t;

endpackage

// File: rtl/qdw_geom.sv
// Slot and descriptor geometry for the latched configuration.
module qdw_geom #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [TAG_W-1:0]  tag,
    input  logic              task16,
    input  logic              addr64,
    input  logic              short_xfer,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [ADDR_W-1:0] link_addr,
    output logic [4:0]        xfer_len
);
    logic [4:0] task_len;
    logic [4:0] link_len;
    logic [5:0] slot_len;

    always_comb begin
        task_len  = task16 ? 5'd16 : 5'd8;
        link_len  = addr64 ? 5'd16 : 5'd8;
        slot_len  = {1'b0, task_len} + {1'b0, link_len};
        xfer_len  = addr64 ? (short_xfer ? 5'd12 : 5'd16) : 5'd8;
        slot_addr = base + ADDR_W'(tag) * ADDR_W'(slot_len);
        link_addr = slot_addr + ADDR_W'(task_len);
    end
endmodule

// File: rtl/qdw_attr_chk.sv
// Attribute check of a descriptor word.
// want_valid=1: valid with the expected action; want_valid=0: invalid with end set.
module qdw_attr_chk (
    input  logic       valid_bit,
    input  logic       end_bit,
    input  logic [2:0] act,
    input  logic [2:0] exp_act,
    input  logic       want_valid,
    output logic       ok
);
    always_comb begin
        if (want_valid) ok = valid_bit && (act == exp_act);
        else            ok = !valid_bit && end_bit;
    end
endmodule

// File: rtl/qdw_walker.sv
module qdw_walker
    import qdw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_SLOTS = 32,
    parameter int DCMD_TAG  = 31,
    parameter int MAX_SEGS  = 8,
    localparam int TAG_W    = $clog2(NUM_SLOTS),
    localparam int CNT_W    = $clog2(MAX_SEGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic [ADDR_W-1:0] cfg_tbl_base,
    input  logic              cfg_task16,
    input  logic              cfg_addr64,
    input  logic              cfg_short_xfer,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [63:0]       seg_addr,
    output logic [15:0]       seg_len,
    output logic              seg_dir,
    output logic              seg_last,
    output logic              done,
    output logic              task_dir,
    output logic [15:0]       task_blk_cnt,
    output logic [31:0]       task_blk_addr,
    output logic              err,
    output logic [2:0]        err_code,
    output logic [TAG_W-1:0]  err_tag
);
    walk_state_t       state_q, state_d;
    fault_t            fault_q, fault_d;
    logic              pend_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] base_q;
    logic              task16_q, addr64_q, short_q;
    logic              dir_q;
    logic [15:0]       cnt_q;
    logic [31:0]       baddr_q;
    logic [ADDR_W-1:0] xptr_q;
    logic [15:0]       slen_q;
    logic              send_q;
    logic [63:0]       saddr_q;
    logic [CNT_W-1:0]  seg_cnt_q;

    logic [ADDR_W-1:0] slot_addr, link_addr;
    logic [4:0]        xfer_len;
    logic [2:0]        exp_act;
    logic              want_valid;
    logic              attr_ok;
    logic              is_dcmd;

    assign is_dcmd = (tag_q == TAG_W'(DCMD_TAG));

    qdw_geom #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_geom (
        .base       (base_q),
        .tag        (tag_q),
        .task16     (task16_q),
        .addr64     (addr64_q),
        .short_xfer (short_q),
        .slot_addr  (slot_addr),
        .link_addr  (link_addr),
        .xfer_len   (xfer_len)
    );

    qdw_attr_chk u_chk (
        .valid_bit  (mem_rd_data[0]),
        .end_bit    (mem_rd_data[1]),
        .act        (mem_rd_data[5:3]),
        .exp_act    (exp_act),
        .want_valid (want_valid),
        .ok         (attr_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        fault_d     = FLT_NONE;
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        exp_act     = ACT_TASK;
        want_valid  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_TASK_A;
            end
            ST_TASK_A: begin
                mem_rd_addr = slot_addr;
                mem_rd_en   = !pend_q;
                if (pend_q) begin
                    state_d = attr_ok ? ST_TASK_B : ST_FAULT;
                    fault_d = FLT_TASK;
                end
            end
            ST_TASK_B: begin
                mem_rd_addr = slot_addr + ADDR_W'(4);
                mem_rd_en   = !pend_q;
                if (pend_q) state_d = ST_LINK_A;
            end
            ST_LINK_A: begin
                mem_rd_addr = link_addr;
                mem_rd_en   = !pend_q;
                exp_act     = ACT_LINK;
                want_valid  = !is_dcmd;
                if (pend_q) begin
                    if (is_dcmd) begin
                        state_d = attr_ok ? ST_DONE : ST_FAULT;
                        fault_d = FLT_DCMD;
                    end else begin
                        state_d = attr_ok ? ST_LINK_B : ST_FAULT;
                        fault_d = FLT_LINK;
                    end
                end
            end
            ST_LINK_B: begin
                mem_rd_addr = link_addr + ADDR_W'(4);
                mem_rd_en   = !pend_q;
                if (pend_q) state_d = ST_XFER_A;
            end
            ST_XFER_A: begin
                mem_rd_addr = xptr_q;
                mem_rd_en   = !pend_q;
                exp_act     = ACT_XFER;
                if (pend_q) begin
                    state_d = attr_ok ? ST_XFER_B : ST_FAULT;
                    fault_d = FLT_XFER;
                end
            end
            ST_XFER_B: begin
                mem_rd_addr = xptr_q + ADDR_W'(4);
                mem_rd_en   = !pend_q;
                if (pend_q) state_d = addr64_q ? ST_XFER_C : ST_EMIT;
            end
            ST_XFER_C: begin
                mem_rd_addr = xptr_q + ADDR_W'(8);
                mem_rd_en   = !pend_q;
                if (pend_q) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (seg_ready) begin
                    if (send_q)                                  state_d = ST_DONE;
                    else if (seg_cnt_q == CNT_W'(MAX_SEGS - 1))  state_d = ST_FAULT;
                    else                                         state_d = ST_XFER_A;
                    fault_d = FLT_LIMIT;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign seg_valid = (state_q == ST_EMIT);
    assign done      = (state_q == ST_DONE);
    assign err       = (state_q == ST_FAULT);

    // datapath captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            tag_q     <= '0;
            base_q    <= '0;
            task16_q  <= 1'b0;
            addr64_q  <= 1'b0;
            short_q   <= 1'b0;
            dir_q     <= 1'b0;
            cnt_q     <= '0;
            baddr_q   <= '0;
            xptr_q    <= '0;
            slen_q    <= '0;
            send_q    <= 1'b0;
            saddr_q   <= '0;
            seg_cnt_q <= '0;
            fault_q   <= FLT_NONE;
        end else begin
            pend_q <= mem_rd_en;
            if (state_q == ST_IDLE && start) begin
                tag_q     <= start_tag;
                base_q    <= cfg_tbl_base;
                task16_q  <= cfg_task16;
                addr64_q  <= cfg_addr64;
                short_q   <= cfg_short_xfer;
                seg_cnt_q <= '0;
                fault_q   <= FLT_NONE;
            end
            if (state_d == ST_FAULT && state_q != ST_FAULT) fault_q <= fault_d;
            if (pend_q) begin
                unique case (state_q)
                    ST_TASK_A: begin
                        dir_q <= mem_rd_data[12];
                        cnt_q <= mem_rd_data[31:16];
                    end
                    ST_TASK_B: baddr_q <= mem_rd_data;
                    ST_LINK_B: xptr_q  <= mem_rd_data[ADDR_W-1:0];
                    ST_XFER_A: begin
                        slen_q <= mem_rd_data[31:16];
                        send_q <= mem_rd_data[1];
                    end
                    ST_XFER_B: saddr_q <= {32'h0, mem_rd_data};
                    ST_XFER_C: saddr_q[63:32] <= mem_rd_data;
                    default: ;
                endcase
            end
            if (state_q == ST_EMIT && seg_ready) begin
                seg_cnt_q <= seg_cnt_q + CNT_W'(1);
                xptr_q    <= xptr_q + ADDR_W'(xfer_len);
            end
        end
    end

    assign seg_addr      = saddr_q;
    assign seg_len       = slen_q;
    assign seg_dir       = dir_q;
    assign seg_last      = send_q;
    assign task_dir      = dir_q;
    assign task_blk_cnt  = cnt_q;
    assign task_blk_addr = baddr_q;
    assign err_code      = fault_q;
    assign err_tag       = tag_q;

    // R7: a stalled record holds
    p_seg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last));

    // R11: one outstanding read, word aligned
    p_rd_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    p_rd_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> mem_rd_addr[1:0] == 2'b00);

    // R8: never more than MAX_SEGS records per walk
    p_seg_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_cnt_q < CNT_W'(MAX_SEGS));

    // R10: the walk's tag holds while busy
    p_tag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(err_tag));

    // R9: the direct-command slot produces no records
    p_dcmd_noseg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> err_tag != TAG_W'(DCMD_TAG));

endmodule

// File: tb/qdw_walker_tb.sv
module qdw_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXS       = 8;
    localparam logic [31:0] BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  start_tag = '0;
    logic        cfg_task16 = 1'b0, cfg_addr64 = 1'b0, cfg_short_xfer = 1'b0;
    logic        busy, mem_rd_en, seg_valid, seg_dir, seg_last, done, task_dir, err;
    logic [31:0] mem_rd_addr, mem_rd_data, task_blk_addr;
    logic        seg_ready = 1'b0;
    logic [63:0] seg_addr;
    logic [15:0] seg_len, task_blk_cnt;
    logic [2:0]  err_code;
    logic [4:0]  err_tag;

    logic [31:0] mem [0:4095];
    int n_chk = 0, n_fail = 0;

    logic [63:0] exp_addr [0:MAXS-1];
    logic [15:0] exp_len  [0:MAXS-1];
    logic        exp_dir;
    logic [15:0] exp_cnt;
    logic [31:0] exp_baddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[13:2]];

    qdw_walker #(.MAX_SEGS(MAXS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_tag(start_tag),
        .cfg_tbl_base(BASE), .cfg_task16(cfg_task16), .cfg_addr64(cfg_addr64),
        .cfg_short_xfer(cfg_short_xfer), .busy(busy), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .seg_valid(seg_valid),
        .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len), .seg_dir(seg_dir),
        .seg_last(seg_last), .done(done), .task_dir(task_dir), .task_blk_cnt(task_blk_cnt),
        .task_blk_addr(task_blk_addr), .err(err), .err_code(err_code), .err_tag(err_tag)
    );

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        mem[a[13:2]] = d;
    endtask

    function automatic int tlen(); return cfg_task16 ? 16 : 8; endfunction
    function automatic int llen(); return cfg_addr64 ? 16 : 8; endfunction
    function automatic int xlen(); return cfg_addr64 ? (cfg_short_xfer ? 12 : 16) : 8; endfunction
    function automatic logic [31:0] slot_of(input int tag);
        return BASE + 32'(tag * (tlen() + llen()));
    endfunction
    function automatic logic [31:0] xbase_of(input int tag);
        return 32'h800 + 32'(tag) * 32'h100;
    endfunction

    // writes a well-formed chain of n transfer descriptors for tag
    task automatic build(input int tag, input int n, input bit end_ok);
        logic [31:0] s, xb, lo, hi, a;
        logic [15:0] ln;
        s  = slot_of(tag);
        xb = xbase_of(tag);
        exp_dir   = 1'($urandom % 2);
        exp_cnt   = 16'($urandom);
        exp_baddr = $urandom;
        put(s, {exp_cnt, 3'b000, exp_dir, 12'h02B});
        put(s + 4, exp_baddr);
        if (cfg_task16) begin put(s + 8, $urandom); put(s + 12, $urandom); end
        put(s + 32'(tlen()), 32'h31);
        put(s + 32'(tlen()) + 4, xb);
        if (cfg_addr64) put(s + 32'(tlen()) + 8, 32'h0);
        for (int i = 0; i < n; i++) begin
            a  = xb + 32'(i * xlen());
            ln = 16'($urandom);
            lo = $urandom;
            hi = cfg_addr64 ? $urandom : 32'h0;
            put(a, {ln, 16'h0021} | ((end_ok && i == n - 1) ? 32'h2 : 32'h0));
            put(a + 4, lo);
            if (cfg_addr64) put(a + 8, hi);
            exp_len[i]  = ln;
            exp_addr[i] = {hi, lo};
        end
    endtask

    task automatic run_walk(input int tag, input int n_exp, input bit exp_end, input bit exp_done,
                            input logic [2:0] exp_code, input bit poke, input string rq);
        int got = 0;
        bit fin = 0;
        bit stall = 0;
        logic [63:0] h_addr;
        logic [15:0] h_len;
        logic        h_last;
        @(negedge clk);
        start = 1'b1; start_tag = 5'(tag);
        @(negedge clk);
        start = 1'b0;
        check(mem_rd_en && mem_rd_addr == slot_of(tag), "R2 first read address", {31'h0, mem_rd_en, mem_rd_addr}, {32'h1, slot_of(tag)});
        for (int cyc = 0; cyc < 2000 && !fin; cyc++) begin
            if (cyc == 1) check(!mem_rd_en, "R11 no read while data pending", 64'(mem_rd_en), 64'h0);
            if (stall)
                check(seg_valid && seg_addr == h_addr && seg_len == h_len && seg_last == h_last,
                      "R7 stalled record held", seg_addr, h_addr);
            if (poke && cyc == 2) begin start = 1'b1; start_tag = 5'(tag ^ 1); end
            else start = 1'b0;
            seg_ready = ($urandom % 3) != 0;
            if (seg_valid && seg_ready) begin
                if (got < n_exp) begin
                    check(seg_addr == exp_addr[got], "R6 seg_addr", seg_addr, exp_addr[got]);
                    check(seg_len == exp_len[got], "R6 seg_len", 64'(seg_len), 64'(exp_len[got]));
                    check(seg_dir == exp_dir, "R6 seg_dir", 64'(seg_dir), 64'(exp_dir));
                    check(seg_last == (exp_end && got == n_exp - 1), "R6 seg_last", 64'(seg_last),
                          64'(exp_end && got == n_exp - 1));
                end
                got++;
            end
            stall  = seg_valid && !seg_ready;
            h_addr = seg_addr; h_len = seg_len; h_last = seg_last;
            if (done || err) begin
                fin = 1;
                check(done == exp_done && err == !exp_done, {rq, " outcome"}, {done, err}, {exp_done, !exp_done});
                check(got == n_exp, {rq, " record count"}, 64'(got), 64'(n_exp));
                if (done && exp_done) begin
                    check(task_blk_cnt == exp_cnt && task_blk_addr == exp_baddr && task_dir == exp_dir,
                          "R4 task fields", {task_dir, task_blk_cnt, task_blk_addr}, {exp_dir, exp_cnt, exp_baddr});
                end
                if (err && !exp_done) begin
                    check(err_code == exp_code, {rq, " err_code"}, 64'(err_code), 64'(exp_code));
                    check(err_tag == 5'(tag), {rq, " err_tag"}, 64'(err_tag), 64'(tag));
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        seg_ready = 1'b0;
        if (!fin) check(1'b0, {rq, " walk never ended"}, 64'h0, 64'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !mem_rd_en && !seg_valid && !done && !err, "R1 reset idle",
              {busy, mem_rd_en, seg_valid, done, err}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !seg_valid, "R1 idle after reset release", {busy, seg_valid}, 64'h0);

        // directed: 32-bit, single segment, tag 0
        cfg_task16 = 0; cfg_addr64 = 0; cfg_short_xfer = 0;
        build(0, 1, 1);
        run_walk(0, 1, 1, 1, 3'd0, 0, "R2");

        // directed R5: 64-bit short descriptors, 16-byte task, three segments
        cfg_task16 = 1; cfg_addr64 = 1; cfg_short_xfer = 1;
        build(5, 3, 1);
        run_walk(5, 3, 1, 1, 3'd0, 0, "R5");

        // random chains
        for (int it = 0; it < 24; it++) begin
            int tg, n;
            cfg_task16 = 1'($urandom); cfg_addr64 = 1'($urandom); cfg_short_xfer = 1'($urandom);
            tg = int'($urandom % 31);
            n  = 1 + int'($urandom % MAXS);
            build(tg, n, 1);
            run_walk(tg, n, 1, 1, 3'd0, 0, "R6");
        end

        // R9: direct-command slot, proper empty link
        cfg_task16 = 0; cfg_addr64 = 1; cfg_short_xfer = 0;
        build(31, 0, 1);
        put(slot_of(31) + 32'(tlen()), 32'h2);
        run_walk(31, 0, 0, 1, 3'd0, 0, "R9");
        // R9: direct-command slot with a valid link is a fault
        put(slot_of(31) + 32'(tlen()), 32'h31);
        run_walk(31, 0, 0, 0, 3'd5, 0, "R9");

        // R3: wrong task action, invalid task, invalid link, invalid transfer
        cfg_task16 = 0; cfg_addr64 = 0; cfg_short_xfer = 0;
        build(3, 2, 1);
        put(slot_of(3), {exp_cnt, 16'h001B});
        run_walk(3, 0, 0, 0, 3'd1, 0, "R3");
        put(slot_of(3), {exp_cnt, 16'h002A});
        run_walk(3, 0, 0, 0, 3'd1, 0, "R3");
        build(4, 2, 1);
        put(slot_of(4) + 32'(tlen()), 32'h30);
        run_walk(4, 0, 0, 0, 3'd2, 0, "R3");
        cfg_addr64 = 1;
        build(6, 3, 1);
        put(xbase_of(6) + 32'(xlen()), 32'h0020);
        run_walk(6, 1, 0, 0, 3'd3, 0, "R3");

        // R8: chain without an end bit
        cfg_addr64 = 0;
        build(9, MAXS, 0);
        run_walk(9, MAXS, 0, 0, 3'd4, 0, "R8");

        // R10: start pulse during a walk is ignored
        cfg_task16 = 1; cfg_addr64 = 1; cfg_short_xfer = 0;
        build(12, 4, 1);
        run_walk(12, 4, 1, 1, 3'd0, 1, "R10");
        repeat (3) @(negedge clk);
        check(!busy, "R10 no second walk started", 64'(busy), 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule